// File: doc/BRIEF.md
# Tagged Multi-Line Receive Queue

This block is the shared receive queue of a four-line serial controller. Characters arriving on any line are pushed with the number of the line they came from. Each queue entry keeps both fields, so a single host read yields the character and its origin. A host read of the receive buffer pops the oldest entry, if there is one. It returns a formatted word: a valid flag, the line field and the character. A registered data-available flag feeds the controller's receive-done logic. A one-cycle acknowledge pulse after every read tells that logic to drop receive-done and the interrupt request.

One line carries a pointing device whose reports are not worth keeping under load. A push from that line is discarded while the queue holds more than half its depth. The other lines can still fill the queue completely.

The queue uses wrapping pointers and computes occupancy as their difference modulo the depth. When an accepted push brings the write pointer onto the read pointer, the stored contents wrap to an empty-looking queue. A sticky overrun flag is raised at that point and stays set until the controller clears it.

Top module: `rxq_tagged`

## Requirements
- R1: After reset, `rx_avail`, `overrun`, `rd_done` are 0 and `rd_word` is all zeros.
- R2: Accepted pushes are returned by reads in arrival order, each with the character and the line number it was pushed with.
- R3: A read that pops an entry loads `rd_word` with bit 15 = 1, bits 9:8 = line, bits 7:0 = character and all other bits 0, visible the cycle after the read.
- R4: A read while the queue is empty loads `rd_word` with all zeros and removes nothing.
- R5: A push on line `MOUSE_LINE` is discarded when occupancy is greater than DEPTH/2; pushes on the other lines are accepted at any occupancy.
- R6: An accepted push that makes occupancy reach DEPTH (pointers meet) sets `overrun`, and the queue then reads as empty.
- R7: `overrun` stays set until `ctl_clear`; if a new overrun and `ctl_clear` fall in the same cycle, `overrun` stays set.
- R8: `rx_avail` is a register that is 1 exactly when the queue holds at least one entry after the clock edge.
- R9: `rd_done` pulses high for one cycle after every read, whether or not the read found data.
- R10: A push and a read in the same cycle are both carried out when the queue is not empty.
- R11: `rd_word` keeps its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_vld | input | 1 | A received character is offered this cycle |
| push_char | input | 8 | Received character |
| push_line | input | 2 | Line number the character arrived on |
| rd_req | input | 1 | Host read of the receive buffer |
| ctl_clear | input | 1 | Controller clear; clears the overrun flag |
| rd_word | output | 16 | Formatted read result: valid, line, character |
| rx_avail | output | 1 | Queue not empty (registered) |
| overrun | output | 1 | Sticky overrun indication |
| rd_done | output | 1 | One-cycle pulse after each read |

## Verification
The push and pop paths meet in one cycle whenever a character arrives during a host read. The interesting cases are an arrival on the pointing-device line while a read lowers occupancy, and an overrun-causing push coinciding with a controller clear. Both are provoked by directed sequences that hold the queue at the half-depth boundary and at DEPTH-1 entries. Random traffic with high push and read rates then overlaps them freely. Each cycle is judged against a bench model of the queue. The model applies the drop rule to the occupancy before the edge, and lets the pop and the accepted push both take effect.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CHAR_W   = 8;
  localparam int LINE_W   = 2;
  localparam int WORD_W   = 16;
  localparam int VALID_B  = 15;
  localparam int LINE_LSB = 8;

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
  parameter int DEPTH      = 64,
  parameter int MOUSE_LINE = 1,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push_vld,
  input  logic [rxq_pkg::LINE_W-1:0] push_line,
  input  logic                      rd_req,
  input  logic                      ctl_clear,
  output logic                      wr_en,
  output logic [AW-1:0]             wr_addr,
  output logic [AW-1:0]             rd_addr,
  output logic                      pop,
  output logic                      avail,
  output logic                      overrun
);
  localparam logic [AW-1:0] HALF = AW'(DEPTH / 2);

  logic [AW-1:0] wptr_q, rptr_q, wptr_d, rptr_d, occ;
  logic          empty_q, empty_d, ovr_q, ovr_d, drop;

  always_comb begin
    occ     = wptr_q - rptr_q;
    drop    = push_vld && (push_line == rxq_pkg::LINE_W'(MOUSE_LINE)) && (occ > HALF);
    wr_en   = push_vld && !drop;
    pop     = rd_req && !empty_q;
    wptr_d  = wr_en ? wptr_q + AW'(1) : wptr_q;
    rptr_d  = pop ? rptr_q + AW'(1) : rptr_q;
    empty_d = (wptr_d == rptr_d);
    ovr_d   = (wr_en && (wptr_d == rptr_d)) || (ovr_q && !ctl_clear);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      empty_q <= 1'b1;
      ovr_q   <= 1'b0;
    end else begin
      if (wr_en) wptr_q <= wptr_d;
      if (pop)   rptr_q <= rptr_d;
      empty_q <= empty_d;
      ovr_q   <= ovr_d;
    end
  end

  assign wr_addr = wptr_q;
  assign rd_addr = rptr_q;
  assign avail   = !empty_q;
  assign overrun = ovr_q;

  // R5
  mouse_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && push_line == rxq_pkg::LINE_W'(MOUSE_LINE) && (wptr_q - rptr_q) > HALF)
      |=> $stable(wptr_q));
  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ctl_clear) |=> ovr_q);
  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty_q) |=> $stable(rptr_q));
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  rxq_pkg::rxq_entry_t  wr_data,
  input  logic [AW-1:0]        rd_addr,
  output rxq_pkg::rxq_entry_t  rd_data
);
  rxq_pkg::rxq_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rxq_fmt.sv
module rxq_fmt (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_req,
  input  logic                         pop,
  input  rxq_pkg::rxq_entry_t          head,
  output logic [rxq_pkg::WORD_W-1:0]   rd_word,
  output logic                         rd_done
);
  import rxq_pkg::*;

  logic [WORD_W-1:0] word_q, word_d;
  logic              done_q;

  always_comb begin
    word_d = '0;
    if (pop) begin
      word_d[VALID_B]                   = 1'b1;
      word_d[LINE_LSB +: LINE_W]        = head.line;
      word_d[CHAR_W-1:0]                = head.ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (rd_req) word_q <= word_d;
      done_q <= rd_req;
    end
  end

  assign rd_word = word_q;
  assign rd_done = done_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_done);
  // R3
  valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && pop) |=> rd_word[VALID_B]);
  // R11
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_word));
endmodule

// File: rtl/rxq_tagged.sv
module rxq_tagged #(
  parameter int DEPTH      = 64,
  parameter int MOUSE_LINE = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_vld,
  input  logic [7:0]  push_char,
  input  logic [1:0]  push_line,
  input  logic        rd_req,
  input  logic        ctl_clear,
  output logic [15:0] rd_word,
  output logic        rx_avail,
  output logic        overrun,
  output logic        rd_done
);
  localparam int AW = $clog2(DEPTH);

  logic                wr_en, pop;
  logic [AW-1:0]       wr_addr, rd_addr;
  rxq_pkg::rxq_entry_t wr_data, head;

  assign wr_data = '{line: push_line, ch: push_char};

  rxq_ptrs #(.DEPTH(DEPTH), .MOUSE_LINE(MOUSE_LINE)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_line(push_line),
    .rd_req(rd_req), .ctl_clear(ctl_clear), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .pop(pop), .avail(rx_avail), .overrun(overrun)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(head)
  );

  rxq_fmt u_fmt (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .pop(pop), .head(head),
    .rd_word(rd_word), .rd_done(rd_done)
  );

  // R10
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && push_line != 2'(MOUSE_LINE) && rd_req && rx_avail && !overrun)
      |=> rx_avail);
endmodule

// File: tb/rxq_tagged_bench.sv
`timescale 1ns/1ps
module rxq_tagged_bench;
  localparam int DEPTH = 64;
  localparam int MOUSE = 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        push_vld = 1'b0, rd_req = 1'b0, ctl_clear = 1'b0;
  logic [7:0]  push_char = '0;
  logic [1:0]  push_line = '0;
  logic [15:0] rd_word;
  logic        rx_avail, overrun, rd_done;

  int tests = 0, fails = 0, cycles = 0;

  // bench model
  logic [9:0] mq [DEPTH];
  int m_w = 0, m_r = 0;
  logic [15:0] e_word = '0;
  logic e_ovr = 1'b0, e_done = 1'b0;

  rxq_tagged #(.DEPTH(DEPTH), .MOUSE_LINE(MOUSE)) u_rxq_tagged (
    .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_char(push_char),
    .push_line(push_line), .rd_req(rd_req), .ctl_clear(ctl_clear),
    .rd_word(rd_word), .rx_avail(rx_avail), .overrun(overrun), .rd_done(rd_done)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cycles++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int occ_of();
    return (m_w - m_r + DEPTH) % DEPTH;
  endfunction

  function automatic logic [15:0] fmt_word(input logic [9:0] e);
    return {1'b1, 5'b0, e[9:8], e[7:0]};
  endfunction

  // one cycle: drive at negedge, update model, compare at next negedge
  task automatic step(input bit p, input logic [7:0] c, input logic [1:0] l,
                      input bit r, input bit clr, input string tag);
    bit pop_m, acc;
    push_vld = p; push_char = c; push_line = l; rd_req = r; ctl_clear = clr;
    pop_m = r && (m_w != m_r);
    acc   = p && !(l == 2'(MOUSE) && occ_of() > DEPTH / 2);
    if (r) e_word = pop_m ? fmt_word(mq[m_r]) : 16'h0;
    if (acc) begin mq[m_w] = {l, c}; m_w = (m_w + 1) % DEPTH; end
    if (pop_m) m_r = (m_r + 1) % DEPTH;
    e_ovr  = (acc && m_w == m_r) || (e_ovr && !clr);
    e_done = r;
    @(negedge clk);
    check(rd_word == e_word, {tag, " R3 word"}, rd_word, e_word);
    check(rx_avail == (m_w != m_r), {tag, " R8 avail"}, rx_avail, m_w != m_r);
    check(overrun == e_ovr, {tag, " R6/R7 overrun"}, overrun, e_ovr);
    check(rd_done == e_done, {tag, " R9 done"}, rd_done, e_done);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h0, 2'd0, 0, 0, "idle R11");
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check(rx_avail == 0 && overrun == 0 && rd_done == 0 && rd_word == 0,
          "R1 reset", {rd_word, rx_avail, overrun, rd_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 read on empty
    step(0, 0, 0, 1, 0, "R4 empty read");
    idle(2);
    // R2 R3 order and tagging
    step(1, 8'h41, 2'd0, 0, 0, "R2 push");
    step(1, 8'h42, 2'd3, 0, 0, "R2 push");
    step(1, 8'h43, 2'd1, 0, 0, "R2 push");
    step(0, 0, 0, 1, 0, "R2 pop");
    idle(2);
    // R10 push and pop together
    step(1, 8'h44, 2'd2, 1, 0, "R10 push+pop");
    step(1, 8'h45, 2'd1, 1, 0, "R10 push+pop");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, "R2 drain");
    // R5 fill to half with line 0, then mouse pushes at boundary
    for (int i = 0; i < DEPTH / 2; i++) step(1, 8'(i), 2'd0, 0, 0, "R5 fill");
    step(1, 8'hA0, 2'd1, 0, 0, "R5 mouse at half accepted");
    step(1, 8'hA1, 2'd1, 0, 0, "R5 mouse over half dropped");
    step(1, 8'hA2, 2'd1, 1, 0, "R5 mouse with pop");
    step(1, 8'hB0, 2'd2, 0, 0, "R5 other line accepted");
    // R6 drive to overrun with line 3, clear in same cycle (R7)
    while (occ_of() < DEPTH - 1) step(1, 8'hC0, 2'd3, 0, 0, "R6 fill");
    step(1, 8'hCF, 2'd3, 0, 1, "R7 overrun beats clear");
    step(0, 0, 0, 1, 0, "R6 reads empty");
    idle(3);
    step(0, 0, 0, 0, 1, "R7 clear");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int rp = (i / 1000) % 2 == 0 ? 70 : 30;
      step(($urandom % 100) < rp, 8'($urandom), 2'($urandom),
           ($urandom % 100) < 50, ($urandom % 100) < 3, "rand R2/R5/R10");
    end
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0, "R2 final drain");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule